// File: doc/BRIEF.md
# Stream Encoder Power-Up Sequencer

This block is the control state machine that brings a display stream encoder up and takes it down again in a fixed order. It owns the stream clock enable and the reset and enable lines of three sub-units: the symbol encoder, the pixel-to-symbol FIFO and the clock-ramp adjuster FIFO. It also drives the video enable, the continuous CRC enable, a one-cycle request that shuts off the secondary data path, and the selected pixel source. The sub-units answer each reset with a reset-done acknowledge, which reaches this block as an input.

A single command port takes four operations: enable, unblank, blank and disable. Unblank also carries a source-select value. Every reset runs as a four-phase handshake. The acknowledge is sampled at a fixed poll interval, and after a bounded number of samples without the expected answer the sequencer stops and raises a timeout error. While a sequence runs, `busy` is high and new commands are dropped. After a timeout, only a disable command is accepted.

Top module: `stream_pwrseq`

## Requirements
- R1: On enable (`cmd_op`=0), `clk_en_o` rises at least one cycle before `enc_rst_o` rises.
- R2: Each reset request stays high until its acknowledge is sampled high, then falls; the next step starts only after the acknowledge is sampled low.
- R3: The acknowledge is sampled one cycle after the reset request changes and then every POLL_CYC cycles. After MAX_POLLS samples without the expected level, `timeout_err` rises exactly 1+(MAX_POLLS-1)*POLL_CYC cycles after the request changed, and `busy` is low.
- R4: Enable ends by setting `enc_en_o` once the symbol encoder reset handshake has completed.
- R5: Unblank (`cmd_op`=1) runs in this order: drive `src_sel_o` with the `cmd_src` captured at acceptance, set `vid_en_o`, run the pixel-to-symbol FIFO handshake, set `p2s_en_o`, run the clock-ramp FIFO handshake, set `crc_en_o`, set `cra_en_o`.
- R6: Blank (`cmd_op`=2) runs in this order: clear `vid_en_o`, pulse `sdp_off_o` high for one cycle, clear `p2s_en_o` (in the cycle that the pulse ends), clear `cra_en_o`.
- R7: Disable (`cmd_op`=3) first clears `enc_en_o` together with any reset request still held, then clears `clk_en_o` in the next cycle.
- R8: An accepted command raises `busy` in the next cycle, and `busy` stays high until the sequence ends. A command that arrives while `busy` is high has no effect.
- R9: After a timeout, every output holds its value and every command except disable is ignored. A disable clears `timeout_err` and runs the disable sequence.
- R10: After reset, every output is low and `src_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled at each rising edge |
| cmd_op | input | 2 | 0 enable, 1 unblank, 2 blank, 3 disable |
| cmd_src | input | SRC_W | Pixel source select captured with unblank |
| busy | output | 1 | A sequence is running |
| timeout_err | output | 1 | An acknowledge wait ran out of polls |
| clk_en_o | output | 1 | Stream clock enable |
| enc_rst_o | output | 1 | Symbol encoder reset request |
| enc_rst_ack_i | input | 1 | Symbol encoder reset-done acknowledge |
| enc_en_o | output | 1 | Symbol encoder enable (idle pattern output) |
| src_sel_o | output | SRC_W | Selected pixel source |
| vid_en_o | output | 1 | Video transmission enable |
| p2s_rst_o | output | 1 | Pixel-to-symbol FIFO reset request |
| p2s_rst_ack_i | input | 1 | Pixel-to-symbol FIFO reset-done acknowledge |
| p2s_en_o | output | 1 | Pixel-to-symbol FIFO enable |
| cra_rst_o | output | 1 | Clock-ramp FIFO reset request |
| cra_rst_ack_i | input | 1 | Clock-ramp FIFO reset-done acknowledge |
| cra_en_o | output | 1 | Clock-ramp FIFO enable |
| crc_en_o | output | 1 | Continuous CRC enable |
| sdp_off_o | output | 1 | One-cycle request to turn off the secondary data path |

## Verification
The bench builds the block with POLL_CYC=4, MAX_POLLS=3 and SRC_W=3. With these values a failed wait ends after nine cycles, so the bench can measure the timeout delay to the exact cycle. The acknowledge delays of one to three cycles land between poll samples, which exercises waits that need more than one sample. Blocking one acknowledge drives the block into the timeout state, and from there the bench checks the ignored commands and the recovery through disable.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [1:0] {
      OP_ENABLE  = 2'd0,
      OP_UNBLANK = 2'd1,
      OP_BLANK   = 2'd2,
      OP_DISABLE = 2'd3
   } seq_op_e;

   typedef enum logic [4:0] {
      S_IDLE, S_EN_CLK, S_EN_HS, S_EN_WAIT, S_EN_ON,
      S_UB_SRC, S_UB_VID, S_UB_P2S_HS, S_UB_P2S_WAIT, S_UB_P2S_ON,
      S_UB_CRA_HS, S_UB_CRA_WAIT, S_UB_CRC, S_UB_CRA_ON,
      S_BL_VID, S_BL_SDP, S_BL_P2S, S_BL_CRA,
      S_DS_ENC, S_DS_CLK, S_FAIL
   } seq_state_e;

   typedef enum logic [1:0] {
      H_IDLE = 2'd0,
      H_UP   = 2'd1,
      H_DOWN = 2'd2
   } hs_phase_e;

   localparam int unsigned HS_ENC   = 0;
   localparam int unsigned HS_P2S   = 1;
   localparam int unsigned HS_CRA   = 2;
   localparam int unsigned HS_COUNT = 3;

endpackage

// File: rtl/pwrseq_poll_timer.sv
module pwrseq_poll_timer #(
   parameter int unsigned POLL_CYC  = 100,
   parameter int unsigned MAX_POLLS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic sample,
   output logic last
);
   localparam int unsigned PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
   localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

   logic [PW-1:0] poll_q;

   generate
      if (POLL_CYC <= 1) begin : g_every_cycle
         assign sample = run;
      end else begin : g_interval
         localparam int unsigned IW = $clog2(POLL_CYC);
         localparam logic [IW-1:0] INT_MAX = IW'(POLL_CYC - 1);
         logic [IW-1:0] int_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               int_q <= '0;
            end else if (restart) begin
               int_q <= '0;
            end else if (run) begin
               int_q <= (int_q == INT_MAX) ? '0 : int_q + 1'b1;
            end
         end

         assign sample = run && (int_q == '0);
      end
   endgenerate

   assign last = (poll_q == LAST_POLL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_q <= '0;
      end else if (restart) begin
         poll_q <= '0;
      end else if (sample && !last) begin
         poll_q <= poll_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwrseq_handshake.sv
module pwrseq_handshake
   import pwrseq_pkg::*;
#(
   parameter int unsigned POLL_CYC  = 100,
   parameter int unsigned MAX_POLLS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clr,
   input  logic ack,
   output logic req_o,
   output logic done_o,
   output logic fail_o
);
   hs_phase_e phase_q;
   logic      sample;
   logic      last;
   logic      restart;
   logic      match;

   assign match   = (phase_q == H_UP) ? ack : !ack;
   assign restart = ((phase_q == H_IDLE) && start) ||
                    ((phase_q == H_UP) && sample && ack);
   assign done_o  = (phase_q == H_DOWN) && sample && !ack;
   assign fail_o  = (phase_q != H_IDLE) && sample && !match && last;

   pwrseq_poll_timer #(
      .POLL_CYC  (POLL_CYC),
      .MAX_POLLS (MAX_POLLS)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (phase_q != H_IDLE),
      .sample  (sample),
      .last    (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= H_IDLE;
         req_o   <= 1'b0;
      end else if (clr) begin
         phase_q <= H_IDLE;
         req_o   <= 1'b0;
      end else begin
         unique case (phase_q)
            H_IDLE: if (start) begin
               req_o   <= 1'b1;
               phase_q <= H_UP;
            end
            H_UP: begin
               if (sample && ack) begin
                  req_o   <= 1'b0;
                  phase_q <= H_DOWN;
               end else if (fail_o) begin
                  phase_q <= H_IDLE;
               end
            end
            H_DOWN: begin
               if (done_o || fail_o) phase_q <= H_IDLE;
            end
            default: phase_q <= H_IDLE;
         endcase
      end
   end

   // R2: the request is only released after the acknowledge was seen high
   a_r2_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(req_o) && !$past(clr)) |-> $past(ack));

   // R2: the request is held while the acknowledge stays low
   a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == H_UP && !ack && !clr) |=> req_o);

endmodule

// File: rtl/stream_pwrseq.sv
module stream_pwrseq
   import pwrseq_pkg::*;
#(
   parameter int unsigned POLL_CYC  = 100,
   parameter int unsigned MAX_POLLS = 10,
   parameter int unsigned SRC_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [SRC_W-1:0] cmd_src,
   output logic             busy,
   output logic             timeout_err,
   output logic             clk_en_o,
   output logic             enc_rst_o,
   input  logic             enc_rst_ack_i,
   output logic             enc_en_o,
   output logic [SRC_W-1:0] src_sel_o,
   output logic             vid_en_o,
   output logic             p2s_rst_o,
   input  logic             p2s_rst_ack_i,
   output logic             p2s_en_o,
   output logic             cra_rst_o,
   input  logic             cra_rst_ack_i,
   output logic             cra_en_o,
   output logic             crc_en_o,
   output logic             sdp_off_o
);

   generate
      if (POLL_CYC < 1) begin : g_bad_poll
         $error("POLL_CYC must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_max
         $error("MAX_POLLS must be at least 1");
      end
      if (SRC_W < 1 || SRC_W > 16) begin : g_bad_src
         $error("SRC_W must lie in 1..16");
      end
   endgenerate

   seq_state_e        state_q;
   seq_op_e           op;
   logic [SRC_W-1:0]  src_hold_q;
   logic [HS_COUNT-1:0] hs_start;
   logic [HS_COUNT-1:0] hs_ack;
   logic [HS_COUNT-1:0] hs_req;
   logic [HS_COUNT-1:0] hs_done;
   logic [HS_COUNT-1:0] hs_fail;
   logic              hs_clr;

   assign op = seq_op_e'(cmd_op);

   assign hs_start[HS_ENC] = (state_q == S_EN_HS);
   assign hs_start[HS_P2S] = (state_q == S_UB_P2S_HS);
   assign hs_start[HS_CRA] = (state_q == S_UB_CRA_HS);
   assign hs_ack[HS_ENC]   = enc_rst_ack_i;
   assign hs_ack[HS_P2S]   = p2s_rst_ack_i;
   assign hs_ack[HS_CRA]   = cra_rst_ack_i;
   assign hs_clr           = (state_q == S_DS_ENC);

   generate
      for (genvar g = 0; g < HS_COUNT; g++) begin : g_hs
         pwrseq_handshake #(
            .POLL_CYC  (POLL_CYC),
            .MAX_POLLS (MAX_POLLS)
         ) i_hs (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (hs_start[g]),
            .clr    (hs_clr),
            .ack    (hs_ack[g]),
            .req_o  (hs_req[g]),
            .done_o (hs_done[g]),
            .fail_o (hs_fail[g])
         );
      end
   endgenerate

   assign enc_rst_o = hs_req[HS_ENC];
   assign p2s_rst_o = hs_req[HS_P2S];
   assign cra_rst_o = hs_req[HS_CRA];
   assign busy      = (state_q != S_IDLE) && (state_q != S_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         src_hold_q  <= '0;
         src_sel_o   <= '0;
         timeout_err <= 1'b0;
         clk_en_o    <= 1'b0;
         enc_en_o    <= 1'b0;
         vid_en_o    <= 1'b0;
         p2s_en_o    <= 1'b0;
         cra_en_o    <= 1'b0;
         crc_en_o    <= 1'b0;
         sdp_off_o   <= 1'b0;
      end else begin
         sdp_off_o <= 1'b0;
         unique case (state_q)
            S_IDLE: if (cmd_valid) begin
               unique case (op)
                  OP_ENABLE:  state_q <= S_EN_CLK;
                  OP_UNBLANK: begin
                     src_hold_q <= cmd_src;
                     state_q    <= S_UB_SRC;
                  end
                  OP_BLANK:   state_q <= S_BL_VID;
                  OP_DISABLE: state_q <= S_DS_ENC;
                  default:    state_q <= S_IDLE;
               endcase
            end
            // enable sequence
            S_EN_CLK: begin
               clk_en_o <= 1'b1;
               state_q  <= S_EN_HS;
            end
            S_EN_HS:   state_q <= S_EN_WAIT;
            S_EN_WAIT: begin
               if (hs_fail[HS_ENC]) begin
                  timeout_err <= 1'b1;
                  state_q     <= S_FAIL;
               end else if (hs_done[HS_ENC]) begin
                  state_q <= S_EN_ON;
               end
            end
            S_EN_ON: begin
               enc_en_o <= 1'b1;
               state_q  <= S_IDLE;
            end
            // unblank sequence
            S_UB_SRC: begin
               src_sel_o <= src_hold_q;
               state_q   <= S_UB_VID;
            end
            S_UB_VID: begin
               vid_en_o <= 1'b1;
               state_q  <= S_UB_P2S_HS;
            end
            S_UB_P2S_HS:   state_q <= S_UB_P2S_WAIT;
            S_UB_P2S_WAIT: begin
               if (hs_fail[HS_P2S]) begin
                  timeout_err <= 1'b1;
                  state_q     <= S_FAIL;
               end else if (hs_done[HS_P2S]) begin
                  state_q <= S_UB_P2S_ON;
               end
            end
            S_UB_P2S_ON: begin
               p2s_en_o <= 1'b1;
               state_q  <= S_UB_CRA_HS;
            end
            S_UB_CRA_HS:   state_q <= S_UB_CRA_WAIT;
            S_UB_CRA_WAIT: begin
               if (hs_fail[HS_CRA]) begin
                  timeout_err <= 1'b1;
                  state_q     <= S_FAIL;
               end else if (hs_done[HS_CRA]) begin
                  state_q <= S_UB_CRC;
               end
            end
            S_UB_CRC: begin
               crc_en_o <= 1'b1;
               state_q  <= S_UB_CRA_ON;
            end
            S_UB_CRA_ON: begin
               cra_en_o <= 1'b1;
               state_q  <= S_IDLE;
            end
            // blank sequence
            S_BL_VID: begin
               vid_en_o <= 1'b0;
               state_q  <= S_BL_SDP;
            end
            S_BL_SDP: begin
               sdp_off_o <= 1'b1;
               state_q   <= S_BL_P2S;
            end
            S_BL_P2S: begin
               p2s_en_o <= 1'b0;
               state_q  <= S_BL_CRA;
            end
            S_BL_CRA: begin
               cra_en_o <= 1'b0;
               state_q  <= S_IDLE;
            end
            // disable sequence
            S_DS_ENC: begin
               enc_en_o <= 1'b0;
               state_q  <= S_DS_CLK;
            end
            S_DS_CLK: begin
               clk_en_o <= 1'b0;
               state_q  <= S_IDLE;
            end
            S_FAIL: begin
               if (cmd_valid && op == OP_DISABLE) begin
                  timeout_err <= 1'b0;
                  state_q     <= S_DS_ENC;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R1: the reset request only rises with the stream clock already on
   a_r1_clk_before_rst: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_rst_o) |-> clk_en_o);

   // R4: the encoder enable rises with its reset released
   a_r4_enable_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_en_o) |-> (clk_en_o && !enc_rst_o));

   // R5: ordering of the unblank steps
   a_r5_p2s_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(p2s_en_o) |-> (vid_en_o && !p2s_rst_o));
   a_r5_cra_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cra_en_o) |-> (crc_en_o && p2s_en_o && !cra_rst_o));

   // R6: ordering of the blank steps
   a_r6_sdp_after_vid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdp_off_o) |-> !vid_en_o);
   a_r6_cra_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cra_en_o) |-> (!p2s_en_o && !vid_en_o));

   // R7: the clock is removed only after enable and resets are cleared
   a_r7_clk_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_o) |-> (!enc_en_o && !enc_rst_o && !p2s_rst_o && !cra_rst_o));

   // R8: an accepted command makes the block busy
   a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !timeout_err && cmd_valid) |=> busy);

   // R3: a timeout leaves the block idle
   a_r3_timeout_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> !busy);

   // R9: outputs hold in the timeout state until a disable arrives
   a_r9_hold_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_err && !(cmd_valid && cmd_op == 2'd3)) |=>
      ($stable({clk_en_o, enc_rst_o, enc_en_o, src_sel_o, vid_en_o, p2s_rst_o,
                p2s_en_o, cra_rst_o, cra_en_o, crc_en_o}) && timeout_err));

endmodule

// File: tb/test_stream_pwrseq.sv
module test_stream_pwrseq;
   localparam int CLK_PERIOD = 10;
   localparam int POLL_CYC   = 4;
   localparam int MAX_POLLS  = 3;
   localparam int SRC_W      = 3;
   localparam int NEV        = 12;
   localparam int TMO_DELAY  = 1 + (MAX_POLLS - 1) * POLL_CYC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [SRC_W-1:0] cmd_src = '0;
   logic busy, timeout_err, clk_en_o, enc_rst_o, enc_en_o, vid_en_o;
   logic p2s_rst_o, p2s_en_o, cra_rst_o, cra_en_o, crc_en_o, sdp_off_o;
   logic [SRC_W-1:0] src_sel_o;
   logic enc_ack, p2s_ack, cra_ack;
   logic blk_cra = 1'b0;
   logic [3:0] pipe_enc = '0, pipe_p2s = '0, pipe_cra = '0;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int t_cra_rise = -1;
   int t_tmo_rise = -1;
   bit mon_on = 1'b0;
   logic [11:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  prev_v [NEV];

   always #(CLK_PERIOD/2) clk = ~clk;

   stream_pwrseq #(
      .POLL_CYC (POLL_CYC), .MAX_POLLS (MAX_POLLS), .SRC_W (SRC_W)
   ) i_stream_pwrseq (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
      .cmd_src (cmd_src), .busy (busy), .timeout_err (timeout_err),
      .clk_en_o (clk_en_o), .enc_rst_o (enc_rst_o), .enc_rst_ack_i (enc_ack),
      .enc_en_o (enc_en_o), .src_sel_o (src_sel_o), .vid_en_o (vid_en_o),
      .p2s_rst_o (p2s_rst_o), .p2s_rst_ack_i (p2s_ack), .p2s_en_o (p2s_en_o),
      .cra_rst_o (cra_rst_o), .cra_rst_ack_i (cra_ack), .cra_en_o (cra_en_o),
      .crc_en_o (crc_en_o), .sdp_off_o (sdp_off_o)
   );

   // acknowledge responders: follow the request after 2, 1 and 3 cycles
   always @(posedge clk) begin
      pipe_enc <= {pipe_enc[2:0], enc_rst_o};
      pipe_p2s <= {pipe_p2s[2:0], p2s_rst_o};
      pipe_cra <= {pipe_cra[2:0], cra_rst_o};
   end
   assign enc_ack = pipe_enc[1];
   assign p2s_ack = pipe_p2s[0];
   assign cra_ack = pipe_cra[2] && !blk_cra;

   function automatic logic [7:0] cur_val(int id);
      case (id)
         0:  return {7'd0, clk_en_o};
         1:  return {7'd0, enc_rst_o};
         2:  return {7'd0, enc_en_o};
         3:  return 8'(src_sel_o);
         4:  return {7'd0, vid_en_o};
         5:  return {7'd0, p2s_rst_o};
         6:  return {7'd0, p2s_en_o};
         7:  return {7'd0, cra_rst_o};
         8:  return {7'd0, cra_en_o};
         9:  return {7'd0, crc_en_o};
         10: return {7'd0, sdp_off_o};
         default: return {7'd0, timeout_err};
      endcase
   endfunction

   task automatic push_ev(int id, int val, string tag);
      exp_q.push_back({4'(id), 8'(val)});
      tag_q.push_back(tag);
   endtask

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: every output change is popped against the scoreboard queue
   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         for (int id = 0; id < NEV; id++) begin
            logic [7:0] v;
            v = cur_val(id);
            if (v !== prev_v[id]) begin
               if (id == 7 && v == 8'd1) t_cra_rise = cyc;
               if (id == 11 && v == 8'd1) t_tmo_rise = cyc;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R8 unexpected output change (id*256+val)",
                        id * 256 + int'(v), -1);
               end else begin
                  logic [11:0] e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(e == {4'(id), v}, t, id * 256 + int'(v),
                        int'(e[11:8]) * 256 + int'(e[7:0]));
               end
               prev_v[id] = v;
            end
         end
      end
   end

   task automatic send(int op, int src, bit accept, string tag);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 2'(op);
      cmd_src   = SRC_W'(src);
      @(negedge clk);
      cmd_valid = 1'b0;
      check(busy == accept, tag, busy, accept);
   endtask

   task automatic wait_idle(string tag);
      while (busy) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   task automatic push_enable();
      push_ev(0, 1, "R1 clk_en rises first");
      push_ev(1, 1, "R1 enc_rst rises after clk_en");
      push_ev(1, 0, "R2 enc_rst released after ack");
      push_ev(2, 1, "R4 enc_en after reset handshake");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R8 watchdog expired (1=done)", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!busy && !timeout_err, "R10 busy/timeout in reset", busy, 0);
      check(!clk_en_o && !enc_rst_o && !enc_en_o, "R10 encoder outputs in reset",
            {clk_en_o, enc_rst_o, enc_en_o}, 0);
      check(!vid_en_o && !p2s_en_o && !cra_en_o && !crc_en_o && !sdp_off_o,
            "R10 stream outputs in reset", vid_en_o, 0);
      check(src_sel_o == '0 && !p2s_rst_o && !cra_rst_o, "R10 src_sel in reset",
            src_sel_o, 0);
      rst_n = 1'b1;
      for (int id = 0; id < NEV; id++) prev_v[id] = cur_val(id);
      mon_on = 1'b1;

      // enable, with an unblank offered while busy
      push_enable();
      send(0, 0, 1'b1, "R8 busy after enable accepted");
      send(1, 6, 1'b1, "R8 still busy during enable");
      wait_idle("R4 enable sequence complete");
      check(!vid_en_o && src_sel_o == '0, "R8 unblank while busy ignored", vid_en_o, 0);

      // unblank from source 5
      push_ev(3, 5, "R5 source latched first");
      push_ev(4, 1, "R5 video enabled");
      push_ev(5, 1, "R5 p2s reset requested");
      push_ev(5, 0, "R2 p2s reset released");
      push_ev(6, 1, "R5 p2s enabled");
      push_ev(7, 1, "R5 cra reset requested");
      push_ev(7, 0, "R2 cra reset released");
      push_ev(9, 1, "R5 crc enabled");
      push_ev(8, 1, "R5 cra enabled last");
      send(1, 5, 1'b1, "R8 busy after unblank accepted");
      wait_idle("R5 unblank sequence complete");

      // blank
      push_ev(4, 0, "R6 video off first");
      push_ev(10, 1, "R6 sdp off pulse");
      push_ev(6, 0, "R6 p2s disabled");
      push_ev(10, 0, "R6 sdp pulse one cycle");
      push_ev(8, 0, "R6 cra disabled last");
      send(2, 0, 1'b1, "R8 busy after blank accepted");
      wait_idle("R6 blank sequence complete");

      // unblank again with the same source: no source or crc change
      push_ev(4, 1, "R5 video enabled again");
      push_ev(5, 1, "R5 p2s reset again");
      push_ev(5, 0, "R2 p2s release again");
      push_ev(6, 1, "R5 p2s enabled again");
      push_ev(7, 1, "R5 cra reset again");
      push_ev(7, 0, "R2 cra release again");
      push_ev(8, 1, "R5 cra enabled again");
      send(1, 5, 1'b1, "R8 busy on second unblank");
      wait_idle("R5 second unblank complete");

      push_ev(4, 0, "R6 video off again");
      push_ev(10, 1, "R6 sdp pulse again");
      push_ev(6, 0, "R6 p2s off again");
      push_ev(10, 0, "R6 sdp pulse end again");
      push_ev(8, 0, "R6 cra off again");
      send(2, 0, 1'b1, "R8 busy on second blank");
      wait_idle("R6 second blank complete");

      // unblank with the clock-ramp acknowledge blocked: timeout
      blk_cra = 1'b1;
      push_ev(3, 2, "R5 new source latched");
      push_ev(4, 1, "R5 video enabled before timeout");
      push_ev(5, 1, "R5 p2s reset before timeout");
      push_ev(5, 0, "R2 p2s release before timeout");
      push_ev(6, 1, "R5 p2s enabled before timeout");
      push_ev(7, 1, "R3 cra reset held");
      push_ev(11, 1, "R3 timeout raised");
      send(1, 2, 1'b1, "R8 busy on blocked unblank");
      wait_idle("R3 timeout sequence seen");
      check(t_tmo_rise - t_cra_rise == TMO_DELAY, "R3 timeout delay in cycles",
            t_tmo_rise - t_cra_rise, TMO_DELAY);
      check(!busy && timeout_err, "R3 not busy after timeout", busy, 0);

      // commands other than disable are ignored after a timeout
      send(2, 0, 1'b0, "R9 blank ignored after timeout");
      send(0, 0, 1'b0, "R9 enable ignored after timeout");
      repeat (4) @(negedge clk);
      check(vid_en_o && cra_rst_o && timeout_err, "R9 outputs held after timeout",
            {vid_en_o, cra_rst_o, timeout_err}, 7);

      // disable recovers
      push_ev(11, 0, "R9 timeout cleared by disable");
      push_ev(2, 0, "R7 enc_en cleared first");
      push_ev(7, 0, "R7 held reset dropped with enc_en");
      push_ev(0, 0, "R7 clk_en removed last");
      send(3, 0, 1'b1, "R9 disable accepted after timeout");
      wait_idle("R7 disable sequence complete");
      blk_cra = 1'b0;

      // enable works again after recovery
      push_enable();
      send(0, 0, 1'b1, "R9 enable accepted after recovery");
      wait_idle("R9 enable after recovery complete");

      // plain disable
      push_ev(2, 0, "R7 enc_en off");
      push_ev(0, 0, "R7 clk_en off");
      send(3, 0, 1'b1, "R8 busy on disable");
      wait_idle("R7 plain disable complete");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule